// File: doc/BRIEF.md
# Mode-Banked UART Register Front End

This block is the software-visible register file of a 16550-style serial port. It decodes a word-aligned byte address (register index times four), keeps the configuration registers, and drives their fields to a separate serializer core. The last value written to the line control register picks one of three register banks. The same offset can therefore reach different storage from one write to the next. Several gating bits decide whether a write lands at all: the enhanced-enable bit, the trigger-level submode bit, the sleep bit, and the mode-register disable state.

A three-state bank machine follows line control writes. Its states are `BANK_OPER`, `BANK_CFG_A` and `BANK_CFG_B`. Any line control write moves it to a new state:
- a write of 0xBF takes it to `BANK_CFG_B`;
- any other value with bit 7 set takes it to `BANK_CFG_A`;
- a value with bit 7 clear takes it to `BANK_OPER`.

No other event changes the state. The character format that the serializer sees is taken only from writes made in operational form. The baud divisor that the serializer sees is taken from the divisor latches only when the mode register leaves its disable value. This lets software reprogram the latches without disturbing a running line.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset the line control register reads 0x00, the mode register (offset 0x20) reads 0x07, the identification register (offset 0x08) reads 0x01 while `irq_req` is low, and `baud_div`, `fifo_en` and `char_len` are 0.
- R2: Writing 0xBF to offset 0x0C selects bank B. Any other value with bit 7 set selects bank A. A value with bit 7 clear selects the operational bank. The written value reads back at 0x0C in every bank.
- R3: In bank B, offset 0x08 is the enhanced feature register (read/write), and offsets 0x00 and 0x04 are the low and high divisor latches. In bank B the modem control offset 0x10 reads 0 and ignores writes.
- R4: In bank A, offsets 0x00 and 0x04 are the divisor latches and offset 0x10 is modem control. In bank A and in the operational bank, offset 0x08 reads identification and accepts FIFO control writes.
- R5: In the operational bank, offset 0x04 is interrupt enable. Bits 3:0 always take a write. Bits 7:4 take a write only while bit 4 of the enhanced feature register is 1.
- R6: The divisor latches keep their value on a write while interrupt enable bit 4 (sleep) is 1.
- R7: Offset 0x1C (trigger level) reads and writes only while enhanced feature bit 4 and modem control bit 6 are both 1. Otherwise it reads 0 and ignores writes, and the stored value returns once the gate reopens.
- R8: `char_len` = bits 1:0, `stop_two` = bit 2 and `parity_cfg` = bits 5:3 of a line control write with bit 7 clear. A write with bit 7 set leaves them unchanged.
- R9: `baud_div` takes {high latch, low latch} in the cycle after a mode register write that changes the mode field (bits 2:0) from 7 to another value. Latch writes and any other mode write leave it unchanged.
- R10: The FIFO control write (offset 0x08, not bank B) stores bit 0 as `fifo_en` and bits 7:6 / 5:4 as `rx_trig` / `tx_trig`. Bits 1 and 2 give one-cycle `rx_flush` / `tx_flush` pulses and are not stored. The identification read returns bit 0 = NOT `irq_req` and bits 7:6 = `fifo_en`.
- R11: Offset 0x40 is a scratch/supplementary register reachable in every bank. The operational offset 0x00 and any unmapped or unaligned address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, register index times four |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for current address |
| irq_req | input | 1 | Serializer has an interrupt pending |
| baud_div | output | 16 | Committed baud divisor |
| mode_sel | output | 3 | Mode register field (7 = disabled, 0 = 16x) |
| char_len | output | 2 | Data bits minus 5 |
| stop_two | output | 1 | Stop count minus 1 |
| parity_cfg | output | 3 | Parity control |
| fifo_en | output | 1 | FIFO enable |
| rx_trig | output | 2 | Receive trigger select |
| tx_trig | output | 2 | Transmit trigger select |
| rx_flush | output | 1 | One-cycle receive FIFO clear |
| tx_flush | output | 1 | One-cycle transmit FIFO clear |
| ier_out | output | 8 | Interrupt enable register |
| mcr_out | output | 8 | Modem control register |
| tlr_out | output | 8 | Trigger level register |
| scr_out | output | 8 | Supplementary control register |

## Verification
The bound checker watches the gating rules on every cycle:
- the upper interrupt enable bits hold while enhanced mode is off;
- the divisor latches and the trigger level hold while their gates are closed;
- `baud_div` moves only on a disable-to-active transition of the mode field;
- flush pulses follow only a FIFO control write;
- the bank state agrees with the stored line control code.

The address aliasing itself can only be shown by the bench's scenarios. These cover what each offset returns in each bank, a blocked write that stays invisible after its bank is left, and stored trigger levels that reappear when the gate reopens.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
    typedef enum logic [1:0] {
        BANK_OPER  = 2'd0,
        BANK_CFG_A = 2'd1,
        BANK_CFG_B = 2'd2
    } bank_e;

    localparam int REG_SHIFT = 2;
    localparam int DATA_W    = 8;

    localparam int IDX_DATA = 0;
    localparam int IDX_IER  = 1;
    localparam int IDX_IIR  = 2;
    localparam int IDX_LCR  = 3;
    localparam int IDX_MCR  = 4;
    localparam int IDX_TLR  = 7;
    localparam int IDX_MDR  = 8;
    localparam int IDX_SCR  = 16;

    localparam logic [7:0] CODE_CFG_B = 8'hBF;
    localparam logic [2:0] MDR_OFF    = 3'd7;
    localparam int         EN_BIT     = 4;
    localparam int         SLEEP_BIT  = 4;
    localparam int         TCRTLR_BIT = 6;
endpackage

// File: rtl/uart_bank_mode.sv
module uart_bank_mode
    import uart_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lcr_we,
    input  logic [7:0] wdata,
    output bank_e      bank,
    output logic [7:0] lcr_q,
    output logic [1:0] char_len,
    output logic       stop_two,
    output logic [2:0] parity_cfg
);
    bank_e bank_nxt;

    // next-state decode from the value being written
    always_comb begin
        bank_nxt = bank;
        if (lcr_we) begin
            if (wdata == CODE_CFG_B)  bank_nxt = BANK_CFG_B;
            else if (wdata[7])        bank_nxt = BANK_CFG_A;
            else                      bank_nxt = BANK_OPER;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank <= BANK_OPER;
        else        bank <= bank_nxt;
    end

    // register image and operational format fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q      <= '0;
            char_len   <= '0;
            stop_two   <= 1'b0;
            parity_cfg <= '0;
        end else if (lcr_we) begin
            lcr_q <= wdata;
            unique case (bank_nxt)
                BANK_OPER: begin
                    char_len   <= wdata[1:0];
                    stop_two   <= wdata[2];
                    parity_cfg <= wdata[5:3];
                end
                BANK_CFG_A, BANK_CFG_B: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_bank_clkdiv.sv
module uart_bank_clkdiv
    import uart_bank_pkg::*;
#(
    parameter int DIV_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dll_we,
    input  logic              dlh_we,
    input  logic              sleep,
    input  logic              mdr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dll_q,
    output logic [DATA_W-1:0] dlh_q,
    output logic [2:0]        mdr_q,
    output logic [DIV_W-1:0]  baud_div
);
    logic commit;
    assign commit = mdr_we && (mdr_q == MDR_OFF) && (wdata[2:0] != MDR_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dll_q    <= '0;
            dlh_q    <= '0;
            mdr_q    <= MDR_OFF;
            baud_div <= '0;
        end else begin
            if (dll_we && !sleep) dll_q <= wdata;
            if (dlh_we && !sleep) dlh_q <= wdata;
            if (mdr_we)           mdr_q <= wdata[2:0];
            if (commit)           baud_div <= {dlh_q, dll_q};
        end
    end
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
    import uart_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              irq_req,
    output logic [15:0]       baud_div,
    output logic [2:0]        mode_sel,
    output logic [1:0]        char_len,
    output logic              stop_two,
    output logic [2:0]        parity_cfg,
    output logic              fifo_en,
    output logic [1:0]        rx_trig,
    output logic [1:0]        tx_trig,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic [7:0]        ier_out,
    output logic [7:0]        mcr_out,
    output logic [7:0]        tlr_out,
    output logic [7:0]        scr_out
);
    localparam int IDX_W = ADDR_W - REG_SHIFT;

    bank_e              bank;
    logic [7:0]         lcr_q, efr_q, dll_q, dlh_q;
    logic [IDX_W-1:0]   idx;
    logic               aligned;
    logic               hit_data, hit_ier, hit_iir, hit_lcr, hit_mcr, hit_tlr, hit_mdr, hit_scr;
    logic               cfg_bank, tlr_open;
    logic               dll_we, dlh_we, ier_we, efr_we, fcr_we, mcr_we, tlr_we, mdr_we, scr_we, lcr_we;

    assign idx      = bus_addr[ADDR_W-1:REG_SHIFT];
    assign aligned  = (bus_addr[REG_SHIFT-1:0] == '0);
    assign hit_data = aligned && idx == IDX_W'(IDX_DATA);
    assign hit_ier  = aligned && idx == IDX_W'(IDX_IER);
    assign hit_iir  = aligned && idx == IDX_W'(IDX_IIR);
    assign hit_lcr  = aligned && idx == IDX_W'(IDX_LCR);
    assign hit_mcr  = aligned && idx == IDX_W'(IDX_MCR);
    assign hit_tlr  = aligned && idx == IDX_W'(IDX_TLR);
    assign hit_mdr  = aligned && idx == IDX_W'(IDX_MDR);
    assign hit_scr  = aligned && idx == IDX_W'(IDX_SCR);

    assign cfg_bank = (bank != BANK_OPER);
    assign tlr_open = efr_q[EN_BIT] && mcr_out[TCRTLR_BIT];

    assign lcr_we = bus_wr && hit_lcr;
    assign dll_we = bus_wr && hit_data && cfg_bank;
    assign dlh_we = bus_wr && hit_ier && cfg_bank;
    assign ier_we = bus_wr && hit_ier && !cfg_bank;
    assign efr_we = bus_wr && hit_iir && bank == BANK_CFG_B;
    assign fcr_we = bus_wr && hit_iir && bank != BANK_CFG_B;
    assign mcr_we = bus_wr && hit_mcr && bank != BANK_CFG_B;
    assign tlr_we = bus_wr && hit_tlr && tlr_open;
    assign mdr_we = bus_wr && hit_mdr;
    assign scr_we = bus_wr && hit_scr;

    uart_bank_mode u_mode (
        .clk(clk), .rst_n(rst_n), .lcr_we(lcr_we), .wdata(bus_wdata),
        .bank(bank), .lcr_q(lcr_q), .char_len(char_len),
        .stop_two(stop_two), .parity_cfg(parity_cfg)
    );

    uart_bank_clkdiv #(.DIV_W(16)) u_div (
        .clk(clk), .rst_n(rst_n), .dll_we(dll_we), .dlh_we(dlh_we),
        .sleep(ier_out[SLEEP_BIT]), .mdr_we(mdr_we), .wdata(bus_wdata),
        .dll_q(dll_q), .dlh_q(dlh_q), .mdr_q(mode_sel), .baud_div(baud_div)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            efr_q    <= '0;
            ier_out  <= '0;
            mcr_out  <= '0;
            tlr_out  <= '0;
            scr_out  <= '0;
            fifo_en  <= 1'b0;
            rx_trig  <= '0;
            tx_trig  <= '0;
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_flush <= fcr_we && bus_wdata[1];
            tx_flush <= fcr_we && bus_wdata[2];
            if (efr_we) efr_q <= bus_wdata;
            if (ier_we) begin
                ier_out[3:0] <= bus_wdata[3:0];
                if (efr_q[EN_BIT]) ier_out[7:4] <= bus_wdata[7:4];
            end
            if (mcr_we) mcr_out <= bus_wdata;
            if (tlr_we) tlr_out <= bus_wdata;
            if (scr_we) scr_out <= bus_wdata;
            if (fcr_we) begin
                fifo_en <= bus_wdata[0];
                tx_trig <= bus_wdata[5:4];
                rx_trig <= bus_wdata[7:6];
            end
        end
    end

    // read multiplexer; anything not listed returns zero
    always_comb begin
        bus_rdata = '0;
        if (hit_lcr)                               bus_rdata = lcr_q;
        else if (hit_mdr)                          bus_rdata = {5'b0, mode_sel};
        else if (hit_scr)                          bus_rdata = scr_out;
        else if (hit_tlr && tlr_open)              bus_rdata = tlr_out;
        else if (hit_data && cfg_bank)             bus_rdata = dll_q;
        else if (hit_ier && cfg_bank)              bus_rdata = dlh_q;
        else if (hit_ier)                          bus_rdata = ier_out;
        else if (hit_iir && bank == BANK_CFG_B)    bus_rdata = efr_q;
        else if (hit_iir)                          bus_rdata = {{2{fifo_en}}, 5'b0, !irq_req};
        else if (hit_mcr && bank != BANK_CFG_B)    bus_rdata = mcr_out;
    end
endmodule

// File: rtl/uart_bank_chk.sv
module uart_bank_chk
    import uart_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input bank_e             bank,
    input logic [7:0]        lcr_q,
    input logic [7:0]        efr_q,
    input logic [7:0]        ier_q,
    input logic [7:0]        mcr_q,
    input logic [7:0]        tlr_q,
    input logic [7:0]        dll_q,
    input logic [7:0]        dlh_q,
    input logic [2:0]        mdr_q,
    input logic [15:0]       baud_div,
    input logic              rx_flush,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata
);
    AST_BANK_B_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        bank == BANK_CFG_B |-> lcr_q == CODE_CFG_B) else $error("bank B without code"); // R2
    AST_BANK_OPER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        bank == BANK_OPER |-> !lcr_q[7]) else $error("operational bank with bit 7 set"); // R2
    AST_IER_HIGH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(efr_q[EN_BIT]) |-> ier_q[7:4] == $past(ier_q[7:4])) else $error("ier high bits moved"); // R5
    AST_DIV_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ier_q[SLEEP_BIT]) |-> $stable(dll_q) && $stable(dlh_q)) else $error("divisor moved in sleep"); // R6
    AST_TLR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(efr_q[EN_BIT] && mcr_q[TCRTLR_BIT]) |-> $stable(tlr_q)) else $error("tlr moved while closed"); // R7
    AST_BAUD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        baud_div != $past(baud_div) |-> $past(mdr_q) == MDR_OFF && mdr_q != MDR_OFF) else $error("baud moved"); // R9
    AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> $past(bus_wr) && $past(bus_addr) == ADDR_W'(8) && $past(bus_wdata[1])
                     && $past(bank) != BANK_CFG_B) else $error("stray flush"); // R10
endmodule

bind uart_bank_regs uart_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bank(bank), .lcr_q(lcr_q), .efr_q(efr_q),
    .ier_q(ier_out), .mcr_q(mcr_out), .tlr_q(tlr_out), .dll_q(dll_q), .dlh_q(dlh_q),
    .mdr_q(mode_sel), .baud_div(baud_div), .rx_flush(rx_flush), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/sim_uart_bank_regs.sv
module sim_uart_bank_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_req = 1'b0;
    logic [15:0] baud_div;
    logic [2:0]  mode_sel, parity_cfg;
    logic [1:0]  char_len, rx_trig, tx_trig;
    logic        stop_two, fifo_en, rx_flush, tx_flush;
    logic [7:0]  ier_out, mcr_out, tlr_out, scr_out;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    uart_bank_regs u0 (.*);

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(8'h0C, d); check("R1 lcr", d, 8'h00);
        rd(8'h20, d); check("R1 mdr", d, 8'h07);
        rd(8'h08, d); check("R1 iir", d, 8'h01);
        check("R1 baud", baud_div, 0);
        check("R1 fifo_en", fifo_en, 0);
        check("R1 char_len", char_len, 0);
    endtask

    task automatic t_banks;
        logic [7:0] d;
        wr(8'h0C, 8'hBF);
        rd(8'h0C, d); check("R2 lcr B", d, 8'hBF);
        wr(8'h08, 8'h10);
        rd(8'h08, d); check("R3 efr", d, 8'h10);
        rd(8'h10, d); check("R3 mcr hidden", d, 0);
        wr(8'h10, 8'h55);
        wr(8'h0C, 8'h80);
        rd(8'h10, d); check("R3 mcr write ignored", d, 0);
        wr(8'h10, 8'h40);
        rd(8'h10, d); check("R4 mcr A", d, 8'h40);
        rd(8'h08, d); check("R4 iir A", d, 8'h01);
        wr(8'h0C, 8'h83);
        rd(8'h10, d); check("R2 other bit7 is A", d, 8'h40);
        check("R8 format held", char_len, 0);
        wr(8'h0C, 8'h1B);
        check("R8 char_len", char_len, 3);
        check("R8 stop", stop_two, 0);
        check("R8 parity", parity_cfg, 3);
        rd(8'h00, d); check("R11 oper data reads 0", d, 0);
        rd(8'h08, d); check("R2 oper iir", d, 8'h01);
        rd(8'h0E, d); check("R11 unaligned", d, 0);
    endtask

    task automatic t_ier_div;
        logic [7:0] d;
        wr(8'h0C, 8'hBF); wr(8'h08, 8'h00); wr(8'h0C, 8'h03);
        wr(8'h04, 8'hF5);
        rd(8'h04, d); check("R5 high blocked", d, 8'h05);
        wr(8'h0C, 8'hBF); wr(8'h08, 8'h10); wr(8'h0C, 8'h03);
        wr(8'h04, 8'hF5);
        rd(8'h04, d); check("R5 high open", d, 8'hF5);
        wr(8'h0C, 8'h80); wr(8'h00, 8'h12);
        rd(8'h00, d); check("R6 dll sleep", d, 0);
        wr(8'h0C, 8'h03); wr(8'h04, 8'h00);
        wr(8'h0C, 8'h80); wr(8'h00, 8'h1A); wr(8'h04, 8'h02);
        rd(8'h00, d); check("R4 dll A", d, 8'h1A);
        rd(8'h04, d); check("R4 dlh A", d, 8'h02);
        wr(8'h0C, 8'hBF);
        rd(8'h00, d); check("R3 dll B", d, 8'h1A);
    endtask

    task automatic t_tlr;
        logic [7:0] d;
        wr(8'h1C, 8'h3C);
        rd(8'h1C, d); check("R7 open", d, 8'h3C);
        wr(8'h0C, 8'h80); wr(8'h10, 8'h00);
        rd(8'h1C, d); check("R7 closed read", d, 0);
        wr(8'h1C, 8'h11);
        wr(8'h10, 8'h40);
        rd(8'h1C, d); check("R7 reopened", d, 8'h3C);
    endtask

    task automatic t_baud;
        check("R9 before commit", baud_div, 0);
        wr(8'h20, 8'h00);
        check("R9 commit", baud_div, 16'h021A);
        wr(8'h00, 8'h34);
        check("R9 latch no effect", baud_div, 16'h021A);
        wr(8'h20, 8'h07);
        wr(8'h20, 8'h07);
        check("R9 disable no effect", baud_div, 16'h021A);
        wr(8'h20, 8'h00);
        check("R9 recommit", baud_div, 16'h0234);
        check("R9 mode", mode_sel, 0);
    endtask

    task automatic t_fifo_scr;
        logic [7:0] d;
        wr(8'h0C, 8'h03);
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 8'h97; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 rx pulse", rx_flush, 1);
        check("R10 tx pulse", tx_flush, 1);
        @(negedge clk);
        check("R10 rx cleared", rx_flush, 0);
        check("R10 tx cleared", tx_flush, 0);
        check("R10 fifo_en", fifo_en, 1);
        check("R10 rx_trig", rx_trig, 2);
        check("R10 tx_trig", tx_trig, 1);
        irq_req = 1'b1;
        rd(8'h08, d); check("R10 iir", d, 8'hC0);
        wr(8'h0C, 8'hBF); wr(8'h40, 8'hA5); wr(8'h0C, 8'h00);
        rd(8'h40, d); check("R11 scr", d, 8'hA5);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_banks();
                t_ier_div();
                t_tlr();
                t_baud();
                t_fifo_scr();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule